// File: doc/BRIEF.md
# Serial Flash Command Front End

This block is the slave-side front end of a small serial flash. It watches the four SPI lines (select, clock, data in, data out) and oversamples them with the system clock, so the host's clock is treated as data and never clocks any logic. It collects the opcode, address and data fields of each instruction and decodes them. It then does one of three things: streams read data back to the host, forwards a program or erase request to a backend, or updates its write-enable and auto-increment state.

Array bytes are fetched through a one-cycle synchronous read port. Each program or erase request is a single-cycle pulse carrying an operation kind, an address and a data byte. A built-in countdown models the time the backend is busy, and its length is set by a parameter for each kind. The host sees that countdown as the busy bit of the status byte. The data output comes with a separate enable, so that the pad can be tri-stated outside it.

Top module: `spif_seq`

## Requirements
- R1: Mode 0 and mode 3 are both accepted. SI is taken on rising SCK edges, MSB first, and a new SO bit appears after each falling edge. `so_oe` is 0 while CS# is high and through every opcode, address and dummy byte.
- R2: Opcode 03h takes a 3-byte address. It then returns the array byte at that address followed by the bytes at rising addresses, one byte per 8 clocks, until CS# rises.
- R3: After the top array address (all ones in `AW` bits), a read stream continues from address 0.
- R4: Opcode 0Bh takes a 3-byte address and one ignored dummy byte, and then streams data as R2 does.
- R5: Opcodes 90h and ABh take 3 address bytes and then alternate BFh and `DEV_ID`. The stream starts with BFh when address bit 0 is 0 and with `DEV_ID` when it is 1.
- R6: Opcode 05h returns the status byte repeatedly. Bit 0 is busy, bit 1 is the write-enable latch (WEL), bit 6 is auto-increment mode, and all other bits are 0.
- R7: Opcode 06h sets WEL. Opcode 04h clears WEL and leaves auto-increment mode.
- R8: Opcode 02h with an address and a data byte issues one `pe_req` on CS# rise (kind 0, that address and byte), but only when WEL is set. The request clears WEL and holds busy for `PROG_CYC` cycles.
- R9: Opcode 20h issues kind 1 with the address rounded down to 4 KiB. Opcode 52h issues kind 2 rounded down to 32 KiB. Opcode 60h issues kind 3 with address 0. Each one needs WEL and clears it.
- R10: If CS# rises before the final bit of an instruction, the instruction has no effect.
- R11: Opcode AFh with an address and data programs that address and enters auto-increment mode with WEL kept. Each later AFh with only a data byte programs the next address.
- R12: Programming the top address in auto-increment mode ends the mode and clears WEL. The address does not wrap.
- R13: Address bits at and above bit `AW` are ignored.
- R14: While busy, every opcode except 05h is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; must be at least 12x the SCK rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | SPI serial clock (asynchronous) |
| cs_n | input | 1 | SPI chip select, active low |
| si | input | 1 | SPI data from host |
| so | output | 1 | SPI data to host |
| so_oe | output | 1 | Output enable for the SO pad |
| mem_en | output | 1 | Array read strobe |
| mem_addr | output | AW | Array read address |
| mem_rdata | input | 8 | Array data, valid the cycle after `mem_en` |
| pe_req | output | 1 | One-cycle program/erase request |
| pe_kind | output | 2 | 0 program, 1 sector, 2 block, 3 chip |
| pe_addr | output | AW | Request address, aligned for erases |
| pe_data | output | 8 | Byte to program |

## Verification
The hardest states to reach from the pins are the two ends of auto-increment programming and the busy window. In both, the block has to refuse a command that would otherwise be valid. The stimulus enters auto-increment mode at the second-to-last address and sends a single data-only continuation. It then reads status at once, which shows the mode gone, WEL cleared and busy still set. For the busy window, a write-enable is sent while the program countdown is still running, and a later status read shows that the latch stayed clear. Truncated frames are cut off in the middle of the data byte, which proves that a fully received address alone does not start a program.

// File: rtl/spif_pkg.sv
package spif_pkg;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_FREAD = 8'h0B;
  localparam logic [7:0] OP_ID_A  = 8'h90;
  localparam logic [7:0] OP_ID_B  = 8'hAB;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_PROG  = 8'h02;
  localparam logic [7:0] OP_SECT  = 8'h20;
  localparam logic [7:0] OP_BLK   = 8'h52;
  localparam logic [7:0] OP_CHIP  = 8'h60;
  localparam logic [7:0] OP_AAI   = 8'hAF;
  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_WRDI  = 8'h04;
  localparam logic [7:0] MFR_ID   = 8'hBF;

  typedef enum logic [2:0] {
    PH_OPC, PH_ADDR, PH_DUMMY, PH_DIN, PH_STREAM, PH_DONE, PH_SKIP
  } phase_e;

  typedef enum logic [3:0] {
    MD_NONE, MD_READ, MD_FREAD, MD_ID, MD_STAT, MD_PROG, MD_AAI,
    MD_SECT, MD_BLK, MD_CHIP, MD_WREN, MD_WRDI
  } mode_e;

  typedef enum logic [1:0] {K_PROG, K_SECT, K_BLK, K_CHIP} kind_e;

  function automatic logic [7:0] stat_byte(input logic busy, input logic wel,
                                           input logic aai);
    return {1'b0, aai, 4'b0000, wel, busy};
  endfunction
endpackage

// File: rtl/spif_rx.sv
module spif_rx (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sck,
  input  logic       cs_n,
  input  logic       si,
  output logic       cs_hi,
  output logic       cs_rise,
  output logic       sck_fall,
  output logic       byte_done,
  output logic [7:0] rx_byte
);
  logic [1:0] sck_p, cs_p;
  logic       si_s, sck_rise;
  logic [2:0] bitcnt;
  logic [6:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_p <= 2'b00;
      cs_p  <= 2'b11;
      si_s  <= 1'b0;
    end else begin
      sck_p <= {sck_p[0], sck};
      cs_p  <= {cs_p[0], cs_n};
      si_s  <= si;
    end
  end

  assign sck_rise  = sck_p[0] & ~sck_p[1];
  assign sck_fall  = ~sck_p[0] & sck_p[1];
  assign cs_hi     = cs_p[0];
  assign cs_rise   = cs_p[0] & ~cs_p[1];
  assign byte_done = sck_rise & ~cs_hi & (bitcnt == 3'd7);
  assign rx_byte   = {sh, si_s};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bitcnt <= '0;
      sh     <= '0;
    end else if (cs_hi) begin
      bitcnt <= '0;
    end else if (sck_rise) begin
      sh     <= {sh[5:0], si_s};
      bitcnt <= bitcnt + 3'd1;
    end
  end

  // R1: the bit counter starts from zero in every frame
  a_r1_frame_restart: assert property (@(posedge clk) disable iff (!rst_n)
    cs_rise |=> (bitcnt == 3'd0));
endmodule

// File: rtl/spif_tx.sv
module spif_tx (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear,
  input  logic       load,
  input  logic [7:0] load_byte,
  input  logic       sck_fall,
  output logic       so,
  output logic       so_oe
);
  logic [7:0] nxt, sh;
  logic       pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nxt <= '0; sh <= '0; pend <= 1'b0; so_oe <= 1'b0;
    end else if (clear) begin
      pend <= 1'b0; so_oe <= 1'b0; sh <= '0;
    end else begin
      if (sck_fall) begin
        if (pend) begin
          sh    <= nxt;
          pend  <= 1'b0;
          so_oe <= 1'b1;
        end else begin
          sh <= {sh[6:0], 1'b0};
        end
      end
      if (load) begin
        nxt  <= load_byte;
        pend <= 1'b1;
      end
    end
  end

  assign so = sh[7];

  // R1: driver released whenever the select is seen high
  a_r1_oe_off_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !so_oe);
  // R1: the output enable only turns on at a falling SCK edge
  a_r1_oe_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(so_oe) |-> $past(sck_fall));
endmodule

// File: rtl/spif_busy_timer.sv
module spif_busy_timer #(
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] len,
  output logic             busy
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (start)      cnt <= len;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);

  // R8: a started operation is reported busy on the next cycle
  a_r8_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    (start && len != '0) |=> busy);
endmodule

// File: rtl/spif_seq.sv
module spif_seq
  import spif_pkg::*;
#(
  parameter int          AW       = 18,
  parameter logic [7:0]  DEV_ID   = 8'h44,
  parameter int          PROG_CYC = 600,
  parameter int          SECT_CYC = 1000,
  parameter int          BLK_CYC  = 1500,
  parameter int          CHIP_CYC = 2000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sck,
  input  logic          cs_n,
  input  logic          si,
  output logic          so,
  output logic          so_oe,
  output logic          mem_en,
  output logic [AW-1:0] mem_addr,
  input  logic [7:0]    mem_rdata,
  output logic          pe_req,
  output logic [1:0]    pe_kind,
  output logic [AW-1:0] pe_addr,
  output logic [7:0]    pe_data
);
  localparam logic [AW-1:0] TOP_ADDR = '1;
  localparam int CNT_W   = $clog2(CHIP_CYC + 1);
  localparam int SECT_SH = 12;
  localparam int BLK_SH  = 15;

  function automatic logic [AW-1:0] align(input logic [AW-1:0] a, input kind_e k);
    case (k)
      K_SECT:  return a & ~((AW'(1) << SECT_SH) - AW'(1));
      K_BLK:   return a & ~((AW'(1) << BLK_SH) - AW'(1));
      K_CHIP:  return '0;
      default: return a;
    endcase
  endfunction

  function automatic logic [CNT_W-1:0] busy_len(input kind_e k);
    case (k)
      K_SECT:  return CNT_W'(SECT_CYC);
      K_BLK:   return CNT_W'(BLK_CYC);
      K_CHIP:  return CNT_W'(CHIP_CYC);
      default: return CNT_W'(PROG_CYC);
    endcase
  endfunction

  logic          cs_hi, cs_rise, sck_fall, byte_done, busy;
  logic [7:0]    rx_byte, tx_byte;
  phase_e        phase;
  mode_e         mode;
  kind_e         kind, mode_kind;
  logic [1:0]    acnt;
  logic [AW-1:0] addr, addr_nxt, ptr, aai_ptr, aai_tgt;
  logic [7:0]    din;
  logic          complete, wel, aai, idsel, fetch_q, fetch_v, rd_mode;

  spif_rx u_rx (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si),
    .cs_hi(cs_hi), .cs_rise(cs_rise), .sck_fall(sck_fall),
    .byte_done(byte_done), .rx_byte(rx_byte)
  );

  spif_tx u_tx (
    .clk(clk), .rst_n(rst_n), .clear(cs_hi), .load(fetch_v), .load_byte(tx_byte),
    .sck_fall(sck_fall), .so(so), .so_oe(so_oe)
  );

  spif_busy_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(pe_req), .len(busy_len(kind)), .busy(busy)
  );

  assign rd_mode  = (mode == MD_READ) || (mode == MD_FREAD);
  assign addr_nxt = AW'({addr, rx_byte});
  assign aai_tgt  = aai ? aai_ptr : addr;
  assign mem_en   = fetch_q & rd_mode;
  assign mem_addr = ptr;
  assign tx_byte  = rd_mode ? mem_rdata :
                    (mode == MD_ID) ? (idsel ? DEV_ID : MFR_ID) :
                    stat_byte(busy, wel, aai);
  assign pe_kind  = kind;

  always_comb begin
    case (mode)
      MD_SECT: mode_kind = K_SECT;
      MD_BLK:  mode_kind = K_BLK;
      MD_CHIP: mode_kind = K_CHIP;
      default: mode_kind = K_PROG;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_OPC; mode <= MD_NONE; acnt <= '0; addr <= '0; din <= '0;
      complete <= 1'b0; wel <= 1'b0; aai <= 1'b0; aai_ptr <= '0; ptr <= '0;
      idsel <= 1'b0; fetch_q <= 1'b0; fetch_v <= 1'b0; pe_req <= 1'b0;
      kind <= K_PROG; pe_addr <= '0; pe_data <= '0;
    end else begin
      fetch_q <= 1'b0;
      fetch_v <= fetch_q;
      pe_req  <= 1'b0;
      if (fetch_v) begin
        if (rd_mode)        ptr   <= ptr + 1'b1;
        if (mode == MD_ID)  idsel <= ~idsel;
      end
      if (cs_hi) begin
        phase <= PH_OPC; acnt <= '0; complete <= 1'b0;
        if (cs_rise && complete) begin
          case (mode)
            MD_WREN: wel <= 1'b1;
            MD_WRDI: begin wel <= 1'b0; aai <= 1'b0; end
            MD_PROG, MD_SECT, MD_BLK, MD_CHIP:
              if (wel) begin
                pe_req <= 1'b1; wel <= 1'b0; kind <= mode_kind;
                pe_addr <= align(addr, mode_kind); pe_data <= din;
              end
            MD_AAI:
              if (aai || wel) begin
                pe_req <= 1'b1; kind <= K_PROG; pe_addr <= aai_tgt; pe_data <= din;
                if (aai_tgt == TOP_ADDR) begin
                  aai <= 1'b0; wel <= 1'b0;
                end else begin
                  aai <= 1'b1; aai_ptr <= aai_tgt + 1'b1;
                end
              end
            default: ;
          endcase
        end
      end else if (byte_done) begin
        case (phase)
          PH_OPC:
            if (busy && rx_byte != OP_RDSR) phase <= PH_SKIP;
            else begin
              case (rx_byte)
                OP_READ:          begin mode <= MD_READ;  phase <= PH_ADDR; end
                OP_FREAD:         begin mode <= MD_FREAD; phase <= PH_ADDR; end
                OP_ID_A, OP_ID_B: begin mode <= MD_ID;    phase <= PH_ADDR; end
                OP_PROG:          begin mode <= MD_PROG;  phase <= PH_ADDR; end
                OP_SECT:          begin mode <= MD_SECT;  phase <= PH_ADDR; end
                OP_BLK:           begin mode <= MD_BLK;   phase <= PH_ADDR; end
                OP_RDSR: begin mode <= MD_STAT; phase <= PH_STREAM; fetch_q <= 1'b1; end
                OP_CHIP: begin mode <= MD_CHIP; phase <= PH_DONE; complete <= 1'b1; end
                OP_WREN: begin mode <= MD_WREN; phase <= PH_DONE; complete <= 1'b1; end
                OP_WRDI: begin mode <= MD_WRDI; phase <= PH_DONE; complete <= 1'b1; end
                OP_AAI:  begin mode <= MD_AAI; phase <= aai ? PH_DIN : PH_ADDR; end
                default: phase <= PH_SKIP;
              endcase
            end
          PH_ADDR: begin
            addr <= addr_nxt;
            acnt <= acnt + 2'd1;
            if (acnt == 2'd2) begin
              case (mode)
                MD_READ:  begin ptr <= addr_nxt; phase <= PH_STREAM; fetch_q <= 1'b1; end
                MD_FREAD: begin ptr <= addr_nxt; phase <= PH_DUMMY; end
                MD_ID:    begin idsel <= rx_byte[0]; phase <= PH_STREAM; fetch_q <= 1'b1; end
                MD_PROG, MD_AAI: phase <= PH_DIN;
                default:  begin phase <= PH_DONE; complete <= 1'b1; end
              endcase
            end
          end
          PH_DUMMY:  begin phase <= PH_STREAM; fetch_q <= 1'b1; end
          PH_DIN:    begin din <= rx_byte; phase <= PH_DONE; complete <= 1'b1; end
          PH_STREAM: fetch_q <= 1'b1;
          default: ;
        endcase
      end
    end
  end

  // R1: data is only driven while a stream phase is open
  a_r1_oe_only_streaming: assert property (@(posedge clk) disable iff (!rst_n)
    so_oe |-> (phase == PH_STREAM) || cs_hi);
  // R3: the read pointer rolls over to zero past the top address
  a_r3_read_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_v && rd_mode && ptr == TOP_ADDR) |=> (ptr == '0));
  // R8: no request without a set write-enable latch, and the latch drops unless auto-increment continues
  a_r8_req_needs_wel: assert property (@(posedge clk) disable iff (!rst_n)
    pe_req |-> $past(wel) && (!wel || aai));
  // R10: a select rise on an incomplete instruction issues nothing
  a_r10_cut_no_req: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && !complete) |=> !pe_req);
  // R12: programming the top address leaves auto-increment mode without WEL
  a_r12_aai_top_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (pe_req && mode == MD_AAI && pe_addr == TOP_ADDR) |-> !aai && !wel);
  // R14: while busy only a status read is decoded
  a_r14_busy_skip: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && byte_done && !cs_hi && phase == PH_OPC && rx_byte != OP_RDSR) |=> (phase == PH_SKIP));
endmodule

// File: tb/spif_seq_bench.sv
`timescale 1ns/1ps
module spif_seq_bench;
  localparam int AW = 18;
  localparam logic [7:0] DEV = 8'h44;
  localparam int H = 6;

  logic clk = 1'b0, rst_n = 1'b0, sck = 1'b0, cs_n = 1'b1, si = 1'b0;
  logic so, so_oe, mem_en, pe_req;
  logic [AW-1:0] mem_addr, pe_addr;
  logic [7:0] mem_rdata = 8'h00, pe_data;
  logic [1:0] pe_kind;

  spif_seq #(.AW(AW), .DEV_ID(DEV)) u_spif_seq (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si), .so(so), .so_oe(so_oe),
    .mem_en(mem_en), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .pe_req(pe_req), .pe_kind(pe_kind), .pe_addr(pe_addr), .pe_data(pe_data)
  );

  always #5 clk = ~clk;

  function automatic logic [7:0] pat(input logic [AW-1:0] a);
    return a[7:0] ^ a[15:8] ^ {6'b0, a[17:16]} ^ 8'h3C;
  endfunction

  always @(posedge clk) mem_rdata <= pat(mem_addr);

  int vectors = 0, miscomp = 0;
  logic [7:0] mosi_q[$];
  logic [7:0] exp_v[$];
  string exp_t[$];
  bit in_cmd = 1'b0, oe_bad = 1'b0;
  int mbit = 0;
  logic [7:0] mbyte = 8'h00;
  int req_n = 0;
  logic [1:0] rk;
  logic [AW-1:0] ra;
  logic [7:0] rd;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscomp++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: assembles bytes the host would sample and pops expectations
  always @(posedge sck) begin
    if (!cs_n) begin
      if (in_cmd) begin
        if (so_oe) oe_bad = 1'b1;
      end else if (so_oe) begin
        mbyte = {mbyte[6:0], so};
        mbit++;
        if (mbit == 8) begin
          mbit = 0;
          vectors++;
          if (exp_v.size() == 0) begin
            miscomp++;
            $display("FAIL unexpected byte: actual %0h expected none", mbyte);
          end else begin
            logic [7:0] ev;
            string et;
            ev = exp_v.pop_front();
            et = exp_t.pop_front();
            if (mbyte !== ev) begin
              miscomp++;
              $display("FAIL %s: actual %0h expected %0h", et, mbyte, ev);
            end
          end
        end
      end
    end
  end

  always @(negedge clk) if (pe_req) begin
    req_n++; rk = pe_kind; ra = pe_addr; rd = pe_data;
  end

  task automatic put(input logic [7:0] b); mosi_q.push_back(b); endtask
  task automatic put_addr(input logic [23:0] a);
    put(a[23:16]); put(a[15:8]); put(a[7:0]);
  endtask
  task automatic want(input logic [7:0] v, input string t);
    exp_v.push_back(v); exp_t.push_back(t);
  endtask

  // driver: one framed transaction; cut >= 0 stops after that many bits
  task automatic spi_run(input bit m3, input int nread, input int cut, input string tag);
    int ncmd;
    ncmd = mosi_q.size() * 8;
    @(negedge clk);
    sck = m3; mbit = 0; oe_bad = 1'b0; in_cmd = 1'b1;
    repeat (H) @(negedge clk);
    cs_n = 1'b0;
    repeat (H) @(negedge clk);
    for (int i = 0; i < ncmd + nread * 8; i++) begin
      if (cut >= 0 && i == cut) break;
      in_cmd = (i < ncmd);
      if (m3) sck = 1'b0;
      si = (i < ncmd) ? mosi_q[i / 8][7 - (i % 8)] : 1'b0;
      repeat (H) @(negedge clk);
      sck = 1'b1;
      repeat (H) @(negedge clk);
      if (!m3) sck = 1'b0;
    end
    repeat (H) @(negedge clk);
    cs_n = 1'b1;
    in_cmd = 1'b1;
    repeat (2 * H) @(negedge clk);
    chk(!oe_bad, {tag, " R1 so_oe during command"}, oe_bad, 0);
    chk(exp_v.size() == 0, {tag, " missing stream bytes"}, exp_v.size(), 0);
    exp_v.delete(); exp_t.delete(); mosi_q.delete();
  endtask

  task automatic status(input logic [7:0] v, input string tag);
    put(8'h05); want(v, tag); want(v, tag);
    spi_run(1'b0, 2, -1, tag);
  endtask

  task automatic simple(input logic [7:0] op, input string tag);
    put(op); spi_run(1'b0, 0, -1, tag);
  endtask

  task automatic finish_up;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    vectors++; miscomp++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    int n0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // reset state (R1)
    chk(so_oe == 1'b0, "R1 reset so_oe", so_oe, 0);
    chk(pe_req == 1'b0 && mem_en == 1'b0, "R8 reset request lines", pe_req, 0);

    // R2 read in mode 0
    put(8'h03); put_addr(24'h001234);
    for (int k = 0; k < 4; k++) want(pat(AW'(24'h001234 + k)), "R2 read stream");
    spi_run(1'b0, 4, -1, "R2");

    // R3 wrap, mode 3 (R1)
    put(8'h03); put_addr(24'h03FFFE);
    want(pat(18'h3FFFE), "R3 wrap"); want(pat(18'h3FFFF), "R3 wrap"); want(pat(18'h00000), "R3 wrap");
    spi_run(1'b1, 3, -1, "R3 mode3");

    // R13 upper address bits ignored
    put(8'h03); put_addr(24'hFC0010);
    want(pat(18'h00010), "R13 high bits"); want(pat(18'h00011), "R13 high bits");
    spi_run(1'b0, 2, -1, "R13");

    // R4 fast read with dummy byte
    put(8'h0B); put_addr(24'h000100); put(8'hA5);
    want(pat(18'h00100), "R4 fast read"); want(pat(18'h00101), "R4 fast read");
    spi_run(1'b1, 2, -1, "R4");

    // R5 identification both openings
    put(8'h90); put_addr(24'h000000);
    want(8'hBF, "R5 id A0=0"); want(DEV, "R5 id A0=0"); want(8'hBF, "R5 id A0=0");
    spi_run(1'b0, 3, -1, "R5a");
    put(8'hAB); put_addr(24'h000001);
    want(DEV, "R5 id A0=1"); want(8'hBF, "R5 id A0=1"); want(DEV, "R5 id A0=1");
    spi_run(1'b0, 3, -1, "R5b");

    // R6 idle status
    status(8'h00, "R6 idle status");

    // R8 program without WEL is dropped
    n0 = req_n;
    put(8'h02); put_addr(24'h000010); put(8'h77); spi_run(1'b0, 0, -1, "R8 nowel");
    chk(req_n == n0, "R8 no request without WEL", req_n - n0, 0);

    // R7 write enable / disable
    simple(8'h06, "R7 wren"); status(8'h02, "R7 WEL set");
    simple(8'h04, "R7 wrdi"); status(8'h00, "R7 WEL cleared");

    // R10 truncated write enable
    put(8'h06); spi_run(1'b0, 0, 5, "R10 cut wren");
    status(8'h00, "R10 cut wren no effect");
    // R10 truncated program, cut inside data byte
    simple(8'h06, "R10 wren");
    n0 = req_n;
    put(8'h02); put_addr(24'h000020); put(8'h55); spi_run(1'b0, 0, 36, "R10 cut prog");
    chk(req_n == n0, "R10 no request on cut frame", req_n - n0, 0);
    status(8'h02, "R10 WEL kept");

    // R8 program request then R14 busy window
    n0 = req_n;
    put(8'h02); put_addr(24'h012345); put(8'hA5); spi_run(1'b0, 0, -1, "R8 prog");
    chk(req_n == n0 + 1, "R8 one request", req_n - n0, 1);
    chk(rk == 2'd0 && ra == 18'h12345 && rd == 8'hA5, "R8 request fields", {rk, ra, rd}, {2'd0, 18'h12345, 8'hA5});
    status(8'h01, "R8 busy and WEL cleared");
    simple(8'h06, "R14 wren while busy");
    repeat (800) @(negedge clk);
    status(8'h00, "R14 wren ignored while busy");

    // R9 erases
    simple(8'h06, "R9");
    put(8'h20); put_addr(24'h012345); spi_run(1'b0, 0, -1, "R9 sector");
    chk(rk == 2'd1 && ra == 18'h12000, "R9 sector erase", {rk, ra}, {2'd1, 18'h12000});
    repeat (1200) @(negedge clk);
    simple(8'h06, "R9");
    put(8'h52); put_addr(24'h01F123); spi_run(1'b0, 0, -1, "R9 block");
    chk(rk == 2'd2 && ra == 18'h18000, "R9 block erase", {rk, ra}, {2'd2, 18'h18000});
    repeat (1700) @(negedge clk);
    simple(8'h06, "R9");
    n0 = req_n;
    simple(8'h60, "R9 chip");
    chk(req_n == n0 + 1 && rk == 2'd3 && ra == '0, "R9 chip erase", {rk, ra}, {2'd3, 18'h0});
    repeat (2200) @(negedge clk);

    // R11 auto-increment programming
    simple(8'h06, "R11");
    put(8'hAF); put_addr(24'h000200); put(8'hD0); spi_run(1'b0, 0, -1, "R11 first");
    chk(rk == 2'd0 && ra == 18'h00200 && rd == 8'hD0, "R11 first byte", {ra, rd}, {18'h00200, 8'hD0});
    repeat (800) @(negedge clk);
    status(8'h42, "R11 mode and WEL held");
    n0 = req_n;
    put(8'hAF); put(8'hD1); spi_run(1'b1, 0, -1, "R11 next");
    chk(req_n == n0 + 1 && ra == 18'h00201 && rd == 8'hD1, "R11 next byte", {ra, rd}, {18'h00201, 8'hD1});
    repeat (800) @(negedge clk);
    simple(8'h04, "R7 end auto-increment");
    status(8'h00, "R7 auto-increment ended");

    // R12 top-address exit
    simple(8'h06, "R12");
    put(8'hAF); put_addr(24'h03FFFE); put(8'h11); spi_run(1'b0, 0, -1, "R12 first");
    repeat (800) @(negedge clk);
    put(8'hAF); put(8'h22); spi_run(1'b0, 0, -1, "R12 last");
    chk(ra == 18'h3FFFF && rd == 8'h22, "R12 top byte programmed", ra, 18'h3FFFF);
    status(8'h01, "R12 mode and WEL cleared");
    repeat (800) @(negedge clk);
    n0 = req_n;
    put(8'hAF); put(8'h33); spi_run(1'b0, 0, -1, "R12 after");
    chk(req_n == n0, "R12 no wrap", req_n - n0, 0);

    finish_up();
  end
endmodule